// File: doc/BRIEF.md
# Host-Side Transmit Sequencer for an ASK/FSK Radio Transmitter

This block drives the three control lines of a crystal-referenced UHF transmitter (carrier-key line, frequency-key line and an optional power-enable line) to send one packet. A packet begins when the byte stream presents its first byte. The sequencer wakes the transmitter with the frequency-key line high and the carrier-key line low. It then waits until the transmitter's returned clock has produced a set number of rising edges, and after that waits a fixed lock interval. Only then does it take bytes and key them out.

Bytes go out most significant bit first. In carrier-keyed mode the carrier-key line follows the line symbol while the frequency-key line is held high. In frequency-keyed mode the carrier-key line is held high so the amplifier stays on, and the frequency-key line follows the symbol. A low symbol selects the lower frequency and a high symbol the higher one. Each bit is split into two halves of `half_div` system clocks. Manchester coding inverts the level in the second half, while NRZ holds one level for the whole bit.

After the byte flagged as last, the carrier-key line drops first and the frequency-key line follows after a short gap. A one-cycle done pulse marks the return to power-down. The returned clock may never appear. In that case a timeout ends the wait, the same power-down order runs, and an error flag is raised.

The byte input is valid/ready. `s_ready` depends only on the sequencer's own state. The producer must hold `s_valid`, `s_data` and `s_last` steady until the cycle in which both are high. Holding `s_valid` while idle starts a packet, but that byte is taken only after the lock interval. If `s_valid` is low when the next byte is due, the line waits in the stall state until data returns.

Top module: `rf_txseq`

## Requirements
- R1: After reset `ask_o`, `fsk_o`, `en_o`, `s_ready`, `done_o` and `err_o` are all 0.
- R2: `s_valid` seen while idle starts a session. From the next cycle `fsk_o`=1 and `ask_o`=0, and `en_o`=1 when `en_wired` was 1 (`en_o` stays 0 otherwise). No byte is accepted yet.
- R3: The sequencer counts rising edges of `xclk` after SYNC_STAGES synchronizer flops. On the DET_EDGES-th edge it begins a wait of LOCK_CYCLES clocks, and only after that wait does `s_ready` rise.
- R4: In carrier-keyed mode (`mode_fsk`=0) `fsk_o`=1 and `ask_o` carries the line symbol. While stalled or waiting for the first byte, `ask_o`=0.
- R5: In frequency-keyed mode (`mode_fsk`=1) `ask_o`=1 from the end of the lock wait through the last bit, and `fsk_o` carries the line symbol.
- R6: Every bit lasts 2×`half_div` clocks, bit 7 of each byte is sent first, and a `half_div` of 0 behaves as 1.
- R7: With `manch_en`=1 a 1 is sent high then low and a 0 low then high, each half lasting `half_div` clocks. With `manch_en`=0 the bit level is held for the whole bit.
- R8: `s_ready` is 1 while waiting for a byte, and in the final clock of a byte's last bit when that byte is not last, so consecutive bytes follow with no gap. A byte accepted with `s_last`=1 ends the packet.
- R9: Shutdown holds `ask_o`=0 and `fsk_o`=1 for GAP_CYCLES clocks, then drives `fsk_o`, `ask_o` and `en_o` to 0 together, with `done_o` high for exactly that one cycle.
- R10: If DET_EDGES edges do not arrive within TIMEOUT_CYCLES clocks of waking, `err_o` is set and shutdown runs as in R9. `err_o` stays 1 until the next session starts.
- R11: `mode_fsk`, `manch_en`, `en_wired` and `half_div` are captured when a session starts, and changes to them during the session have no effect on the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Byte available |
| s_data | input | BYTE_W | Byte to send |
| s_last | input | 1 | Marks the final byte of the packet |
| s_ready | output | 1 | Byte accepted when high together with s_valid |
| mode_fsk | input | 1 | 1 frequency-keyed, 0 carrier-keyed |
| manch_en | input | 1 | 1 Manchester, 0 NRZ |
| en_wired | input | 1 | 1 when the enable line is driven by this block |
| half_div | input | DIV_W | Half-bit length in system clocks |
| xclk | input | 1 | Clock returned by the transmitter, asynchronous |
| ask_o | output | 1 | Carrier-key (amplifier on) line |
| fsk_o | output | 1 | Frequency-key line |
| en_o | output | 1 | Power-enable line |
| done_o | output | 1 | One-cycle pulse on return to power-down |
| err_o | output | 1 | Clock-wait timeout flag |

## Verification
The checker assumes nothing about `xclk` except that it is sampled through the synchronizer. Its properties are framed as relations between the three control lines, done and error, so they hold whatever the stimulus does. The per-cycle model assumes that the producer keeps the byte steady until accepted and that `xclk` never changes at a rising system-clock edge. The bench drives all inputs at falling edges and toggles the returned clock at an offset from both edges, which keeps it inside both assumptions. The returned clock toggles only while the bench's transmitter model sees power, and it can be held dead to reach the timeout.

// File: rtl/rf_txseq_pkg.sv
package rf_txseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_LOCK,
    ST_LOAD,
    ST_SEND,
    ST_TAIL,
    ST_DOWN
  } seq_st_t;

  typedef struct packed {
    logic fsk_mode;
    logic manch;
    logic en_wired;
  } sess_cfg_t;

  // Second half of a Manchester bit carries the inverted level.
  function automatic logic line_sym(input logic b, input logic second_half,
                                    input logic manch);
    return manch ? (b ^ second_half) : b;
  endfunction

endpackage

// File: rtl/rf_txseq_clkmon.sv
module rf_txseq_clkmon #(
  parameter int SYNC_STAGES    = 2,
  parameter int DET_EDGES      = 4,
  parameter int TIMEOUT_CYCLES = 140000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xclk_a,
  input  logic arm,
  output logic seen_p,
  output logic tmo_p
);
  localparam int EW = $clog2(DET_EDGES + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise;
  logic [EW-1:0]          ecnt_q;
  logic [TW-1:0]          tcnt_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= xclk_a;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];

  assign rise   = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign seen_p = arm & rise & (ecnt_q == EW'(DET_EDGES - 1));
  assign tmo_p  = arm & ~seen_p & (tcnt_q == TW'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt_q <= '0;
      tcnt_q <= '0;
    end else if (!arm) begin
      ecnt_q <= '0;
      tcnt_q <= '0;
    end else begin
      if (rise) ecnt_q <= ecnt_q + 1'b1;
      if (tcnt_q != TW'(TIMEOUT_CYCLES - 1)) tcnt_q <= tcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rf_txseq_baud.sv
module rf_txseq_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] hdiv,
  output logic             ph,
  output logic             half_end,
  output logic             bit_end
);
  logic [DIV_W-1:0] hcnt_q;

  assign half_end = run & (hcnt_q == hdiv - 1'b1);
  assign bit_end  = half_end & ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      ph     <= 1'b0;
    end else if (!run) begin
      hcnt_q <= '0;
      ph     <= 1'b0;
    end else if (half_end) begin
      hcnt_q <= '0;
      ph     <= ~ph;
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rf_txseq_shift.sv
module rf_txseq_shift
  import rf_txseq_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [BYTE_W-1:0] din,
  input  logic              din_last,
  input  logic              ph,
  input  logic              manch,
  output logic              cur_sym,
  output logic              at_end,
  output logic              last_q
);
  localparam int BW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh_q;
  logic [BW-1:0]     idx_q;
  logic              cur_bit;
  logic [BYTE_W-1:0] sh_nxt;

  if (MSB_FIRST) begin : g_msb
    assign cur_bit = sh_q[BYTE_W-1];
    assign sh_nxt  = {sh_q[BYTE_W-2:0], 1'b0};
  end else begin : g_lsb
    assign cur_bit = sh_q[0];
    assign sh_nxt  = {1'b0, sh_q[BYTE_W-1:1]};
  end

  assign at_end  = (idx_q == BW'(BYTE_W - 1));
  assign cur_sym = line_sym(cur_bit, ph, manch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      sh_q   <= din;
      idx_q  <= '0;
      last_q <= din_last;
    end else if (adv) begin
      sh_q   <= sh_nxt;
      idx_q  <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/rf_txseq.sv
module rf_txseq
  import rf_txseq_pkg::*;
#(
  parameter int DIV_W          = 16,
  parameter int BYTE_W         = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int DET_EDGES      = 4,
  parameter int TIMEOUT_CYCLES = 140000,
  parameter int LOCK_CYCLES    = 25000,
  parameter int GAP_CYCLES     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              mode_fsk,
  input  logic              manch_en,
  input  logic              en_wired,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              xclk,
  output logic              ask_o,
  output logic              fsk_o,
  output logic              en_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int WC_MAX = (LOCK_CYCLES > GAP_CYCLES) ? LOCK_CYCLES : GAP_CYCLES;
  localparam int WW     = $clog2(WC_MAX + 1);

  seq_st_t          st_q;
  sess_cfg_t        cfg_q;
  logic [DIV_W-1:0] hdiv_q;
  logic             err_q;
  logic [WW-1:0]    wcnt_q;

  logic seen_p, tmo_p;
  logic ph, half_end, bit_end;
  logic cur_sym, at_end, last_q;
  logic byte_end, load, adv;

  rf_txseq_clkmon #(
    .SYNC_STAGES   (SYNC_STAGES),
    .DET_EDGES     (DET_EDGES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_clkmon (
    .clk   (clk),
    .rst_n (rst_n),
    .xclk_a(xclk),
    .arm   (st_q == ST_WAKE),
    .seen_p(seen_p),
    .tmo_p (tmo_p)
  );

  rf_txseq_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st_q == ST_SEND),
    .hdiv    (hdiv_q),
    .ph      (ph),
    .half_end(half_end),
    .bit_end (bit_end)
  );

  assign byte_end = bit_end & at_end;
  assign s_ready  = (st_q == ST_LOAD) | ((st_q == ST_SEND) & byte_end & ~last_q);
  assign load     = s_valid & s_ready;
  assign adv      = (st_q == ST_SEND) & bit_end & ~at_end;

  rf_txseq_shift #(.BYTE_W(BYTE_W), .MSB_FIRST(1'b1)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .adv     (adv),
    .din     (s_data),
    .din_last(s_last),
    .ph      (ph),
    .manch   (cfg_q.manch),
    .cur_sym (cur_sym),
    .at_end  (at_end),
    .last_q  (last_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      hdiv_q <= DIV_W'(1);
      err_q  <= 1'b0;
      wcnt_q <= '0;
    end else begin
      wcnt_q <= '0;
      case (st_q)
        ST_IDLE: if (s_valid) begin
          cfg_q.fsk_mode <= mode_fsk;
          cfg_q.manch    <= manch_en;
          cfg_q.en_wired <= en_wired;
          hdiv_q         <= (half_div == '0) ? DIV_W'(1) : half_div;
          err_q          <= 1'b0;
          st_q           <= ST_WAKE;
        end
        ST_WAKE: begin
          if (seen_p) st_q <= ST_LOCK;
          else if (tmo_p) begin
            err_q <= 1'b1;
            st_q  <= ST_TAIL;
          end
        end
        ST_LOCK: begin
          if (wcnt_q == WW'(LOCK_CYCLES - 1)) st_q <= ST_LOAD;
          else wcnt_q <= wcnt_q + 1'b1;
        end
        ST_LOAD: if (s_valid) st_q <= ST_SEND;
        ST_SEND: if (byte_end) begin
          if (last_q)        st_q <= ST_TAIL;
          else if (!s_valid) st_q <= ST_LOAD;
        end
        ST_TAIL: begin
          if (wcnt_q == WW'(GAP_CYCLES - 1)) st_q <= ST_DOWN;
          else wcnt_q <= wcnt_q + 1'b1;
        end
        ST_DOWN: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ask_o = 1'b0;
    fsk_o = 1'b0;
    en_o  = 1'b0;
    case (st_q)
      ST_WAKE, ST_LOCK, ST_TAIL: begin
        fsk_o = 1'b1;
        en_o  = cfg_q.en_wired;
      end
      ST_LOAD: begin
        ask_o = cfg_q.fsk_mode;
        fsk_o = 1'b1;
        en_o  = cfg_q.en_wired;
      end
      ST_SEND: begin
        ask_o = cfg_q.fsk_mode ? 1'b1 : cur_sym;
        fsk_o = cfg_q.fsk_mode ? cur_sym : 1'b1;
        en_o  = cfg_q.en_wired;
      end
      default: ;
    endcase
  end

  assign done_o = (st_q == ST_DOWN);
  assign err_o  = err_q;

endmodule

// File: rtl/rf_txseq_chk.sv
module rf_txseq_chk (
  input logic clk,
  input logic rst_n,
  input logic ask_o,
  input logic fsk_o,
  input logic en_o,
  input logic done_o,
  input logic err_o
);
  // R9
  done_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!ask_o && !fsk_o && !en_o));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  fsk_drop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ask_o && $fell(fsk_o)) |-> done_o);

  // R2
  en_has_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |-> (ask_o || fsk_o));

  // R10
  err_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (fsk_o && !ask_o));

endmodule

bind rf_txseq rf_txseq_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ask_o (ask_o),
  .fsk_o (fsk_o),
  .en_o  (en_o),
  .done_o(done_o),
  .err_o (err_o)
);

// File: tb/sim_rf_txseq.sv
module sim_rf_txseq;
  localparam int DIV_W = 16, DET = 3, TMO = 200, LOCK = 50, GAP = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic       mode_fsk = 1'b0, manch_en = 1'b0, en_wired = 1'b0;
  logic [DIV_W-1:0] half_div = 16'd3;
  logic       xclk = 1'b0, xtal_ok = 1'b1;
  wire        s_ready, ask_o, fsk_o, en_o, done_o, err_o;

  int errors = 0, checks = 0;

  rf_txseq #(.DIV_W(DIV_W), .BYTE_W(8), .SYNC_STAGES(2), .DET_EDGES(DET),
             .TIMEOUT_CYCLES(TMO), .LOCK_CYCLES(LOCK), .GAP_CYCLES(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .mode_fsk(mode_fsk), .manch_en(manch_en), .en_wired(en_wired),
    .half_div(half_div), .xclk(xclk), .ask_o(ask_o), .fsk_o(fsk_o), .en_o(en_o),
    .done_o(done_o), .err_o(err_o));

  // Transmitter stand-in: clock toggles only while powered, away from clk edges.
  wire powered = en_wired ? en_o : (ask_o | fsk_o);
  initial begin
    #2;
    forever begin
      #20;
      xclk = (powered && xtal_ok) ? ~xclk : 1'b0;
    end
  end

  // Behavioural reference: 0 idle,1 wake,2 lock,3 wait byte,4 send,5 tail,6 down
  int m_st = 0, m_cyc = 0, m_edges = 0, m_pc = 0, m_bi = 0, m_h = 1;
  bit m_fsk = 0, m_man = 0, m_enw = 0, m_last = 0, m_err = 0;
  bit m_s1 = 0, m_s2 = 0, m_prev = 0;
  logic [7:0] m_byte = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_err = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      bit rise;
      rise = m_s2 && !m_prev;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = xclk;
      case (m_st)
        0: if (s_valid) begin
          m_fsk = mode_fsk; m_man = manch_en; m_enw = en_wired;
          m_h = (half_div == 0) ? 1 : int'(half_div);
          m_err = 0; m_st = 1; m_cyc = 0; m_edges = 0;
        end
        1: begin
          if (rise && m_edges + 1 == DET) begin m_st = 2; m_cyc = 0; end
          else if (m_cyc == TMO - 1) begin m_err = 1; m_st = 5; m_cyc = 0; end
          else begin m_cyc++; if (rise) m_edges++; end
        end
        2: if (m_cyc == LOCK - 1) m_st = 3; else m_cyc++;
        3: if (s_valid) begin m_byte = s_data; m_last = s_last; m_bi = 0; m_pc = 0; m_st = 4; end
        4: begin
          if (m_pc == 2 * m_h - 1) begin
            m_pc = 0;
            if (m_bi == 7) begin
              if (m_last) begin m_st = 5; m_cyc = 0; end
              else if (s_valid) begin m_byte = s_data; m_last = s_last; m_bi = 0; end
              else m_st = 3;
            end else m_bi++;
          end else m_pc++;
        end
        5: if (m_cyc == GAP - 1) m_st = 6; else m_cyc++;
        default: m_st = 0;
      endcase
    end
  end

  task automatic note(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  bit cmp_on = 0;
  always @(negedge clk) if (cmp_on && rst_n) begin
    bit ea, ef, ee, er, sym;
    string lt;
    ea = 0; ef = 0; ee = 0; sym = 0;
    case (m_st)
      1, 2, 5: begin ef = 1; ee = m_enw; end
      3: begin ea = m_fsk; ef = 1; ee = m_enw; end
      4: begin
        sym = m_byte[7 - m_bi] ^ (m_man && m_pc >= m_h);
        ea = m_fsk ? 1'b1 : sym; ef = m_fsk ? sym : 1'b1; ee = m_enw;
      end
      default: ;
    endcase
    er = (m_st == 3) || (m_st == 4 && m_pc == 2 * m_h - 1 && m_bi == 7 && !m_last);
    case (m_st)
      0: lt = "R1";
      1, 2: lt = "R2 R3";
      3, 4: lt = m_fsk ? "R5 R6 R7 R11" : "R4 R6 R7 R11";
      default: lt = "R9";
    endcase
    note(lt, "ask_o", ask_o, ea);
    note(lt, "fsk_o", fsk_o, ef);
    note("R2", "en_o", en_o, ee);
    note("R8", "s_ready", s_ready, er);
    note("R9", "done_o", done_o, m_st == 6);
    note("R10", "err_o", err_o, m_err);
  end

  logic [7:0] txq[$];

  task automatic setcfg(input bit f, input bit m, input bit e, input int h);
    @(negedge clk);
    mode_fsk = f; manch_en = m; en_wired = e; half_div = DIV_W'(h);
  endtask

  task automatic run_pkt(input int stall_at, input bit scramble);
    int i = 0;
    bit took = 0;
    s_valid = 1; s_data = txq[0]; s_last = (txq.size() == 1);
    forever begin
      @(negedge clk);
      if (done_o) begin s_valid = 0; break; end
      if (took) begin
        i++;
        if (scramble && i == 1) begin
          mode_fsk = ~mode_fsk; manch_en = ~manch_en; half_div = half_div + 2;
        end
        if (i == txq.size()) begin s_valid = 0; break; end
        s_data = txq[i]; s_last = (i == txq.size() - 1);
        if (i == stall_at) begin
          s_valid = 0; repeat (40) @(negedge clk); s_valid = 1;
        end
      end
      took = s_valid && s_ready;
    end
    while (!done_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    note("R1", "reset lines", {ask_o, fsk_o, en_o, s_ready, done_o, err_o}, 0);
    cmp_on = 1;

    // R4 R6 carrier keyed NRZ, enable wired, two bytes
    setcfg(0, 0, 1, 3); txq = {8'hA5, 8'h3C}; run_pkt(-1, 0);
    // R4 R7 R11 carrier keyed Manchester, shared wiring, settings changed mid-packet
    setcfg(0, 1, 0, 2); txq = {8'h96, 8'h01}; run_pkt(-1, 1);
    // R5 R7 R8 frequency keyed Manchester, minimum divider, stall between bytes
    setcfg(1, 1, 1, 1); txq = {8'hF0, 8'h0F, 8'h5A}; run_pkt(1, 0);
    // R5 R6 frequency keyed NRZ, divider 0 acts as 1
    setcfg(1, 0, 0, 0); txq = {8'hC3}; run_pkt(-1, 0);

    // R10 dead crystal: timeout, shutdown, sticky error
    xtal_ok = 0;
    setcfg(0, 0, 1, 2); txq = {8'h77}; run_pkt(-1, 0);
    note("R10", "err held after abort", err_o, 1);
    xtal_ok = 1;
    setcfg(1, 0, 1, 2); txq = {8'h81}; s_valid = 1; s_data = 8'h81; s_last = 1;
    repeat (2) @(negedge clk);
    note("R10", "err cleared on new start", err_o, 0);
    s_valid = 0; s_valid = 1;
    run_pkt(-1, 0);

    cmp_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule